// File: doc/BRIEF.md
# Phase-Interleaved Shared RAM Arbiter

This block lets a processor and a read-only display fetcher use one synchronous RAM without either side ever waiting. Each processor bus cycle is divided into two halves by the processor clock phase, which is sampled on a faster system clock. While the phase is low, the display fetcher's address reaches the RAM. While the phase is high, the processor's address reaches the RAM. One processor cycle therefore yields two RAM accesses. At a 1 MHz processor rate, that is two million accesses per second.

The RAM write enable is gated by the phase, so a write can never land in the display half. The write enable is also held off for the first system-clock edge after the phase rises, so the write only happens once the processor address has had a tick to settle. The display side never writes. As a result, the processor's read-modify-write sequences need no locking. Display data is registered when the low half ends and is marked by a one-tick valid pulse. Processor read data is registered when the high half ends, which is the end of the processor cycle.

The phase must stay at each level for at least two system-clock ticks. A phase that is high or low for a single tick breaks the capture timing described in R4 and R5.

Top module: `phase_ram_arbiter`

## Requirements
- R1: While `phase` is 0, `mem_addr` equals `vid_addr`; while `phase` is 1, `mem_addr` equals `cpu_addr`, selected combinationally from `phase`.
- R2: `mem_we` is 1 only while `phase` is 1 and `cpu_we` is 1; it is never 1 while `phase` is 0.
- R3: At the first clock edge after `phase` goes from 0 to 1, `mem_we` is 0, even when `cpu_we` is 1; on later high-phase edges it follows `cpu_we`.
- R4: At the first clock edge after `phase` rises, `vid_rdata` takes the RAM word at the `vid_addr` held through the low half, and `vid_valid` is 1 for exactly that one following cycle. `vid_rdata` changes at no other time.
- R5: At the first clock edge after `phase` falls, `cpu_rdata` takes the RAM word at `cpu_addr` as read at the last high-phase edge; it holds its value at all other times.
- R6: A word written by the processor is returned by a later display read of the same address, and by a later processor read of that address.
- R7: With `rst_n` low at a clock edge, `vid_valid`, `vid_rdata` and `cpu_rdata` become 0.
- R8: Display reads leave RAM contents unchanged: a processor read after any number of display reads returns the last processor-written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 1 | Processor clock phase: 0 = display half, 1 = processor half |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_we | input | 1 | Processor write request (1 = write, 0 = read) |
| cpu_rdata | output | DATA_W | Processor read data, registered when the high half ends |
| vid_addr | input | ADDR_W | Display fetch address |
| vid_rdata | output | DATA_W | Display read data, registered when the low half ends |
| vid_valid | output | 1 | One-tick pulse marking new `vid_rdata` |
| mem_addr | output | ADDR_W | Address presented to the RAM |
| mem_we | output | 1 | Write enable presented to the RAM |

## Verification
`mem_addr` and the `mem_we` gating respond within the same tick as a phase or request change. The bench therefore samples them 1 ns after driving the inputs on a falling clock edge. The display result appears one system-clock edge after the phase rises, so the bench samples `vid_rdata` and `vid_valid` at the first falling edge of the high half, and checks `vid_valid` low again one falling edge later. The processor result appears one edge after the phase falls, so it is checked at the first falling edge of the next low half. The expected values come from a bench-side model of the RAM that is updated only by processor writes.

// File: rtl/arb_pkg.sv
// Shared types for the phase-interleaved RAM arbiter.
// Assumes nothing beyond IEEE 1800-2017.
package arb_pkg;
    // Which side owns the RAM address bus in the current half cycle.
    typedef enum logic {
        OWN_VIDEO = 1'b0,
        OWN_CPU   = 1'b1
    } owner_e;
endpackage

// File: rtl/arb_phase_seq.sv
// Phase sequencer: registers the processor clock phase on the system clock,
// flags the first tick of each half and derives the gated write enable.
// Assumes phase is synchronous to clk and holds each level for >= 2 ticks.
module arb_phase_seq
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   phase,
    input  logic   cpu_we,
    output owner_e owner,
    output logic   rise,
    output logic   fall,
    output logic   we_gated
);
    logic phase_q;

    // Remember the phase seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase;
    end

    // Edge flags and ownership, all straight from the live phase.
    always_comb begin
        rise     = phase & ~phase_q;
        fall     = ~phase & phase_q;
        owner    = phase ? OWN_CPU : OWN_VIDEO;
        we_gated = phase & cpu_we & ~rise;
    end
endmodule

// File: rtl/arb_spram.sv
// Single-port synchronous RAM model, read-before-write, one access per edge.
// Assumes the caller keeps addr stable across the edge; contents unreset.
module arb_spram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // One access per edge: optional write, registered old-data read.
    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
        rdata <= store[addr];
    end
endmodule

// File: rtl/arb_capture.sv
// Capture register: loads d when load is set and raises a one-tick strobe.
// Assumes load is a single-tick pulse; holds q otherwise.
module arb_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              strobe
);
    // Hold or reload the captured word and mark the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            strobe <= 1'b0;
        end else begin
            if (load) q <= d;
            strobe <= load;
        end
    end
endmodule

// File: rtl/phase_ram_arbiter.sv
// Phase-interleaved shared RAM arbiter: the display fetcher reads the RAM in
// the low phase half, the processor reads or writes it in the high half.
// Assumes phase is synchronous to clk and holds each level >= 2 ticks.
module phase_ram_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [DATA_W-1:0] vid_rdata,
    output logic              vid_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we
);
    owner_e            owner;
    logic              rise;
    logic              fall;
    logic              cpu_cap_done;
    logic [DATA_W-1:0] ram_q;

    arb_phase_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .cpu_we   (cpu_we),
        .owner    (owner),
        .rise     (rise),
        .fall     (fall),
        .we_gated (mem_we)
    );

    // Address mux, selected by the owner of the current half.
    always_comb begin
        mem_addr = (owner == OWN_CPU) ? cpu_addr : vid_addr;
    end

    arb_spram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (cpu_wdata),
        .rdata (ram_q)
    );

    // Display word: taken when the low half ends.
    arb_capture #(.DATA_W(DATA_W)) u_vid_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (rise),
        .d      (ram_q),
        .q      (vid_rdata),
        .strobe (vid_valid)
    );

    // Processor word: taken when the high half ends.
    arb_capture #(.DATA_W(DATA_W)) u_cpu_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (fall),
        .d      (ram_q),
        .q      (cpu_rdata),
        .strobe (cpu_cap_done)
    );

    assert_we_only_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (phase && cpu_we));

    assert_we_off_first_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && !$past(phase)) |-> !mem_we);

    assert_vid_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |=> !vid_valid);

    assert_vid_changes_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vid_rdata) |-> vid_valid);

    assert_cpu_changes_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_rdata) |-> cpu_cap_done);

    assert_cpu_capture_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_cap_done |-> !phase);
endmodule

// File: tb/phase_ram_arbiter_tb.sv
module phase_ram_arbiter_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          phase = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_we = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic [AW-1:0] vid_addr = '0;
    logic [DW-1:0] vid_rdata;
    logic          vid_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_we;

    int n_checks = 0;
    int n_fail = 0;

    logic [DW-1:0] model [DEPTH];
    bit            known [DEPTH];
    bit            cpu_pending = 1'b0;
    logic [DW-1:0] cpu_expect = '0;

    always #5 clk = ~clk;

    phase_ram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_rdata(cpu_rdata), .vid_addr(vid_addr), .vid_rdata(vid_rdata),
        .vid_valid(vid_valid), .mem_addr(mem_addr), .mem_we(mem_we)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One processor cycle: low half for the display read, high half for the CPU.
    task automatic bus_cycle(input logic [AW-1:0] va, input logic [AW-1:0] ca,
                             input logic [DW-1:0] wd, input logic w);
        phase = 1'b0;
        vid_addr = va;
        cpu_we = 1'b0;
        #1;
        check(mem_addr == va, "R1 low mux", mem_addr, va);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (i == 1 && cpu_pending) begin
                check(cpu_rdata == cpu_expect, "R5/R6/R8 cpu read", cpu_rdata, cpu_expect);
                cpu_pending = 1'b0;
            end
            check(mem_we == 1'b0, "R2 no write in low half", mem_we, 0);
            check(mem_addr == va, "R1 low mux", mem_addr, va);
        end
        phase = 1'b1;
        cpu_addr = ca;
        cpu_wdata = wd;
        cpu_we = w;
        #1;
        check(mem_we == 1'b0, "R3 write held off first tick", mem_we, 0);
        check(mem_addr == ca, "R1 high mux", mem_addr, ca);
        @(negedge clk);
        check(vid_valid == 1'b1, "R4 valid pulse", vid_valid, 1);
        if (known[va])
            check(vid_rdata == model[va], "R4/R6 video data", vid_rdata, model[va]);
        check(mem_we == w, "R2/R3 write after first tick", mem_we, w);
        if (w) begin
            model[ca] = wd;
            known[ca] = 1'b1;
        end
        if (known[ca]) begin
            cpu_pending = 1'b1;
            cpu_expect = model[ca];
        end
        @(negedge clk);
        check(vid_valid == 1'b0, "R4 valid single tick", vid_valid, 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) known[a] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(vid_valid == 1'b0, "R7 reset valid", vid_valid, 0);
        check(vid_rdata == '0, "R7 reset video data", vid_rdata, 0);
        check(cpu_rdata == '0, "R7 reset cpu data", cpu_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Pass 1: write every word, display reads the previous address.
        for (int a = 0; a < DEPTH; a++)
            bus_cycle(AW'(a - 1), AW'(a), DW'(a * 7 + 3), 1'b1);
        // Pass 2: read every word back, display sweeps downward.
        for (int a = 0; a < DEPTH; a++)
            bus_cycle(AW'(DEPTH - 1 - a), AW'(a), DW'(8'h5a), 1'b0);
        // Pass 3: read-modify-write on a few words, display reads the same word.
        for (int a = 0; a < 16; a++) begin
            bus_cycle(AW'(a * 3), AW'(a * 3), '0, 1'b0);
            bus_cycle(AW'(a * 3), AW'(a * 3), ~model[a * 3], 1'b1);
            bus_cycle(AW'(a * 3), AW'(a * 3), '0, 1'b0);
        end
        bus_cycle('0, '0, '0, 1'b0);
        bus_cycle('0, '0, '0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule